// File: doc/BRIEF.md
# Indirect Lookup-RAM Access Port

This block gives a host bus access to a small internal lookup memory of 128 bytes through three registers. The host loads a pointer register with a 7-bit location and an auto-advance flag, and for a store it loads a data register. It then writes a control register to raise either a load strobe or a store strobe. The block carries out the memory access. On a load it returns the byte into the data register, and in either case it then drops the strobe by itself. Software finds out that the access has finished by polling the strobe bit.

When the auto-advance flag is set, the pointer steps by one at the end of every load or store, wrapping from 127 to 0. The stepped value can be read back from the pointer register. While a strobe is pending, the block ignores every host register write, so the access in progress sees stable operands. Register reads are combinational and have no side effects.

Top module: `lkp_access_port`

## Requirements
- R1: After reset the pointer, data and control registers all read 0x00, and so does register index 3.
- R2: Register index 0 is the pointer: bits 6:0 hold the location and bit 7 holds the auto-advance flag, and a written value reads back unchanged. Index 1 is the data byte. Index 2 is control: bit 1 is the load strobe, bit 0 is the store strobe, and bits 7:2 always read zero. Index 3 reads zero.
- R3: A write of 0x01 to control stores the data byte at the pointed location. Control reads 0x01 in the cycle after that bus write and 0x00 from the cycle after that.
- R4: A write of 0x02 to control loads the byte at the pointed location into the data register. Control reads 0x02 for the two cycles after the bus write. It reads 0x00 from the third cycle, when the data register already holds the loaded byte.
- R5: With bit 7 of the pointer set, the location field reads one higher once a load or a store has finished, and the flag stays set.
- R6: With bit 7 of the pointer clear, the location field is unchanged after a load or a store.
- R7: An advance from location 127 gives location 0.
- R8: A control write with both bits 1 and 0 set performs only the store. Control reads 0x01 in the next cycle and 0x00 after that.
- R9: Host writes to any register while a strobe is pending are ignored. The pointer, the flag and the data byte keep their values.
- R10: A control write with bits 1:0 both zero starts no access: the pointer does not advance and control stays 0x00. Bits 7:2 of a control write have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Host selects the block this cycle |
| bus_wr | input | 1 | Host write when high together with bus_sel |
| bus_idx | input | 2 | Register index: 0 pointer, 1 data, 2 control, 3 reserved |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Combinational read data of the indexed register |

## Verification
The end of an access and the auto-advance of the pointer fall in the same clock edge. For a load, the captured byte also lands in the data register at that edge. Full sweeps over all 128 locations, first with stores and then with loads, both with the flag set, provoke this at every location, including the 127-to-0 wrap. The bench judges each access at the ports: it expects control to read zero, the data register to hold the byte from its own model and the pointer to read one higher. A second sweep with the flag clear, together with bus writes timed to land while a strobe is pending, checks that the pointer and data stay put when no advance or host write is allowed.

// File: rtl/lkp_pkg.sv
// Package lkp_pkg
// Shared register indices and sequencer state encoding for the lookup-RAM
// access port. Assumes a two-bit register index on the host side.
package lkp_pkg;

    localparam logic [1:0] IDX_PTR  = 2'd0;
    localparam logic [1:0] IDX_DATA = 2'd1;
    localparam logic [1:0] IDX_CTRL = 2'd2;

    localparam int CTRL_STORE_BIT = 0;
    localparam int CTRL_LOAD_BIT  = 1;

    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_CAPT = 1'b1
    } seq_state_t;

endpackage

// File: rtl/lkp_ram.sv
// Module lkp_ram
// Single-port synchronous memory of 2**ADDR_W words. A store takes effect at
// the clock edge where wr_en is high; a load registers the word onto rd_data
// at the edge where rd_en is high. Assumes the two enables are never high
// together. Contents are not reset, only the output register is.
module lkp_ram #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store port: write the addressed word.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[addr] <= wr_data;
        end
    end

    // Load port: register the addressed word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= mem[addr];
        end
    end

    // R8: the sequencer never stores and loads in the same cycle.
    assert_no_dual_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && rd_en));

endmodule

// File: rtl/lkp_sequencer.sv
// Module lkp_sequencer
// Turns a pending strobe into memory cycles. A store uses one cycle: the
// memory write enable is raised and the access completes at the same edge.
// A load uses two cycles: the first presents the location to the memory and
// the second captures its output. Assumes at most one strobe is pending.
module lkp_sequencer
    import lkp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_pend,
    input  logic store_pend,
    output logic mem_we,
    output logic mem_re,
    output logic capture,
    output logic done
);

    seq_state_t state_q;

    // State register: go to capture after presenting a load location.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else begin
            unique case (state_q)
                SEQ_IDLE: if (load_pend) state_q <= SEQ_CAPT;
                SEQ_CAPT: state_q <= SEQ_IDLE;
                default:  state_q <= SEQ_IDLE;
            endcase
        end
    end

    // Memory controls and completion pulse from state and pending strobes.
    always_comb begin
        mem_we  = (state_q == SEQ_IDLE) && store_pend;
        mem_re  = (state_q == SEQ_IDLE) && load_pend;
        capture = (state_q == SEQ_CAPT);
        done    = mem_we || capture;
    end

    // R4: a capture always follows a cycle that presented a load location.
    assert_capture_after_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> $past(mem_re));

    // R4: a load keeps its strobe pending while it is in capture.
    assert_capture_has_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> load_pend);

endmodule

// File: rtl/lkp_regs.sv
// Module lkp_regs
// Host-visible register file: pointer (location and auto-advance flag), data
// byte and control strobes. Host writes are accepted only when no strobe is
// pending. A combined strobe write keeps only the store. On completion both
// strobes clear and the pointer advances when the flag is set. Assumes
// ADDR_W + 1 <= DATA_W so that the flag fits in the pointer byte's top bit.
module lkp_regs
    import lkp_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [1:0]        bus_idx,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              done,
    input  logic              capture,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] ptr_addr,
    output logic [DATA_W-1:0] data_byte,
    output logic              load_pend,
    output logic              store_pend
);

    localparam int PAD_W = DATA_W - 1 - ADDR_W;
    localparam logic [ADDR_W-1:0] ADDR_STEP = {{(ADDR_W-1){1'b0}}, 1'b1};

    logic              adv_flag;
    logic              busy;
    logic              host_we;
    logic [DATA_W-1:0] ptr_byte;
    logic [DATA_W-1:0] ctrl_byte;

    // Host write qualification: blocked while any strobe is pending.
    always_comb begin
        busy    = load_pend || store_pend;
        host_we = bus_sel && bus_wr && !busy;
    end

    // Pointer register: host load, or auto-advance at completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_addr <= '0;
            adv_flag <= 1'b0;
        end else if (host_we && bus_idx == IDX_PTR) begin
            ptr_addr <= bus_wdata[ADDR_W-1:0];
            adv_flag <= bus_wdata[DATA_W-1];
        end else if (done && adv_flag) begin
            ptr_addr <= ptr_addr + ADDR_STEP;
        end
    end

    // Data register: host load, or captured memory word at load completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_byte <= '0;
        end else if (capture) begin
            data_byte <= mem_rdata;
        end else if (host_we && bus_idx == IDX_DATA) begin
            data_byte <= bus_wdata;
        end
    end

    // Strobe register: set by host (store wins), cleared at completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_pend  <= 1'b0;
            store_pend <= 1'b0;
        end else if (done) begin
            load_pend  <= 1'b0;
            store_pend <= 1'b0;
        end else if (host_we && bus_idx == IDX_CTRL) begin
            store_pend <= bus_wdata[CTRL_STORE_BIT];
            load_pend  <= bus_wdata[CTRL_LOAD_BIT] && !bus_wdata[CTRL_STORE_BIT];
        end
    end

    // Pointer byte packing: flag on top, zero padding when the field is narrow.
    generate
        if (PAD_W > 0) begin : g_ptr_pad
            assign ptr_byte = {adv_flag, {PAD_W{1'b0}}, ptr_addr};
        end else begin : g_ptr_nopad
            assign ptr_byte = {adv_flag, ptr_addr};
        end
    endgenerate

    assign ctrl_byte = {{(DATA_W-2){1'b0}}, load_pend, store_pend};

    // Read multiplexer: combinational view of the indexed register.
    always_comb begin
        unique case (bus_idx)
            IDX_PTR:  bus_rdata = ptr_byte;
            IDX_DATA: bus_rdata = data_byte;
            IDX_CTRL: bus_rdata = ctrl_byte;
            default:  bus_rdata = '0;
        endcase
    end

    // R8: at most one strobe is ever pending.
    assert_single_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_pend && store_pend));

    // R3: a store strobe is pending for exactly one cycle.
    assert_store_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        store_pend |=> !store_pend);

    // R4: a fresh load strobe is still pending in the next cycle.
    assert_load_second_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(load_pend) |=> load_pend);

    // R4: a load strobe clears after its second cycle.
    assert_load_two_cycles_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_pend && $past(load_pend)) |=> !load_pend);

    // R9: while an access is in flight the pointer and flag hold.
    assert_ptr_held_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> ($stable(ptr_addr) && $stable(adv_flag)));

    // R5: completion with the flag set steps the pointer by one.
    assert_ptr_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && adv_flag) |=> (ptr_addr == $past(ptr_addr) + ADDR_STEP));

    // R6: completion with the flag clear leaves the pointer alone.
    assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !adv_flag) |=> $stable(ptr_addr));

endmodule

// File: rtl/lkp_access_port.sv
// Module lkp_access_port
// Top level of the indirect lookup-RAM access port: host register file,
// access sequencer and the 2**ADDR_W by DATA_W memory. Assumes a host that
// drives bus_sel/bus_wr for one cycle per register write and polls the
// control register for completion.
module lkp_access_port #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [1:0]        bus_idx,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);

    logic [ADDR_W-1:0] ptr_addr;
    logic [DATA_W-1:0] data_byte;
    logic [DATA_W-1:0] mem_rdata;
    logic              load_pend;
    logic              store_pend;
    logic              mem_we;
    logic              mem_re;
    logic              capture;
    logic              done;

    lkp_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_idx    (bus_idx),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .done       (done),
        .capture    (capture),
        .mem_rdata  (mem_rdata),
        .ptr_addr   (ptr_addr),
        .data_byte  (data_byte),
        .load_pend  (load_pend),
        .store_pend (store_pend)
    );

    lkp_sequencer u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_pend  (load_pend),
        .store_pend (store_pend),
        .mem_we     (mem_we),
        .mem_re     (mem_re),
        .capture    (capture),
        .done       (done)
    );

    lkp_ram #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mem_we),
        .rd_en   (mem_re),
        .addr    (ptr_addr),
        .wr_data (data_byte),
        .rd_data (mem_rdata)
    );

endmodule

// File: tb/lkp_access_port_test.sv
// Bench for lkp_access_port: full store/load sweeps over all locations with
// expected values computed from the requirements.
module lkp_access_port_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_idx = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] model [128];
    logic [7:0] v;

    always #10 clk = ~clk;

    lkp_access_port uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_idx   (bus_idx),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic host_wr(input logic [1:0] idx, input logic [7:0] val);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_idx = idx; bus_wdata = val;
        @(posedge clk);
        #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic peek(input logic [1:0] idx, output logic [7:0] r);
        bus_idx = idx;
        #1;
        r = bus_rdata;
    endtask

    // Store at the pointer; control 01 then 00; pointer then reads exp_ptr.
    task automatic op_store(input string tag, input logic [7:0] exp_ptr);
        logic [7:0] r;
        host_wr(2'd2, 8'h01);
        @(negedge clk); peek(2'd2, r); check({tag, " R3 strobe set"}, r, 8'h01);
        @(negedge clk); peek(2'd2, r); check({tag, " R3 strobe clear"}, r, 8'h00);
        peek(2'd0, r); check({tag, " pointer"}, r, exp_ptr);
    endtask

    // Load at the pointer; control 02,02,00; data then exp_dat, pointer exp_ptr.
    task automatic op_load(input string tag, input logic [7:0] exp_dat, input logic [7:0] exp_ptr);
        logic [7:0] r;
        host_wr(2'd2, 8'h02);
        @(negedge clk); peek(2'd2, r); check({tag, " R4 strobe cycle 1"}, r, 8'h02);
        @(negedge clk); peek(2'd2, r); check({tag, " R4 strobe cycle 2"}, r, 8'h02);
        @(negedge clk); peek(2'd2, r); check({tag, " R4 strobe clear"}, r, 8'h00);
        peek(2'd1, r); check({tag, " R4 data"}, r, exp_dat);
        peek(2'd0, r); check({tag, " pointer"}, r, exp_ptr);
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values
        for (int k = 0; k < 4; k++) begin
            peek(k[1:0], v); check("R1 reset value", v, 8'h00);
        end
        // R2: pointer readback and reserved index
        host_wr(2'd0, 8'hA5);
        @(negedge clk); peek(2'd0, v); check("R2 pointer readback", v, 8'hA5);
        peek(2'd3, v); check("R2 reserved index", v, 8'h00);
        host_wr(2'd1, 8'h3C);
        @(negedge clk); peek(2'd1, v); check("R2 data readback", v, 8'h3C);

        // R5 / R7: store sweep with auto-advance from location 0
        host_wr(2'd0, 8'h80);
        for (int i = 0; i < 128; i++) begin
            model[i] = 8'((i * 37 + 5) & 255);
            host_wr(2'd1, model[i]);
            op_store((i == 127) ? "R7 store wrap" : "R5 store advance",
                     8'h80 | 8'((i + 1) & 127));
        end
        // R5 / R7: load sweep with auto-advance, pointer wrapped to 0
        for (int i = 0; i < 128; i++) begin
            op_load((i == 127) ? "R7 load wrap" : "R5 load advance",
                    model[i], 8'h80 | 8'((i + 1) & 127));
        end

        // R6: store sweep with flag clear
        for (int i = 0; i < 128; i++) begin
            model[i] = ~8'(i) ^ 8'h5A;
            host_wr(2'd0, 8'(i));
            host_wr(2'd1, model[i]);
            op_store("R6 store hold", 8'(i));
        end
        // R6: load sweep in reverse order with flag clear
        for (int i = 127; i >= 0; i--) begin
            host_wr(2'd0, 8'(i));
            op_load("R6 load hold", model[i], 8'(i));
        end

        // R7: single load at 127 with advance
        host_wr(2'd0, 8'hFF);
        op_load("R7 single wrap", model[127], 8'h80);

        // R8: both strobes -> store only
        host_wr(2'd0, 8'h05);
        host_wr(2'd1, 8'hC3);
        host_wr(2'd2, 8'h03);
        @(negedge clk); peek(2'd2, v); check("R8 only store pending", v, 8'h01);
        @(negedge clk); peek(2'd2, v); check("R8 strobe clear", v, 8'h00);
        peek(2'd1, v); check("R8 data unchanged", v, 8'hC3);
        model[5] = 8'hC3;
        host_wr(2'd1, 8'h00);
        op_load("R8 stored value", 8'hC3, 8'h05);

        // R9: pointer write during a pending load is ignored
        host_wr(2'd0, 8'h0A);
        host_wr(2'd2, 8'h02);
        host_wr(2'd0, 8'hA1);
        @(negedge clk);
        @(negedge clk); peek(2'd2, v); check("R9 load done", v, 8'h00);
        peek(2'd0, v); check("R9 pointer held", v, 8'h0A);
        peek(2'd1, v); check("R9 load data", v, model[10]);
        // R9: data write during a pending store is ignored
        host_wr(2'd1, 8'h6E);
        host_wr(2'd2, 8'h01);
        host_wr(2'd1, 8'h11);
        @(negedge clk); peek(2'd1, v); check("R9 data held", v, 8'h6E);
        peek(2'd2, v); check("R9 store done", v, 8'h00);
        model[10] = 8'h6E;
        host_wr(2'd1, 8'h00);
        op_load("R9 stored value", 8'h6E, 8'h0A);

        // R10: control writes without strobe bits start nothing
        host_wr(2'd0, 8'h90);
        host_wr(2'd2, 8'h00);
        @(negedge clk); peek(2'd2, v); check("R10 zero control", v, 8'h00);
        @(negedge clk); peek(2'd0, v); check("R10 no advance", v, 8'h90);
        host_wr(2'd2, 8'hFC);
        @(negedge clk); peek(2'd2, v); check("R10 upper bits control", v, 8'h00);
        @(negedge clk); peek(2'd0, v); check("R10 upper bits no advance", v, 8'h90);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule